// File: doc/BRIEF.md
# Page-Banked Packet Register Window

This block presents a 256-byte register space to a slow byte-wide bus. The bottom 64 bytes are a read-only window onto a received packet, the one at the head of an external packet queue. A page register picks which 64-byte slice of that packet is visible. Changing the page copies the new slice from word-wide packet storage into the window, one 32-bit word per clock. While the copy runs, the bus is stalled with a wait signal, so the window is never seen half-updated.

The queue itself lies outside the block. It offers a head descriptor (valid flag, word base address, length in bytes) and removes its head when the block pulses a pop output. When nothing is loaded and the queue has a head, the block takes that head and fills page 0 by itself. Software drops the current packet by writing a release register. The block then pops the queue and, once the next head appears, loads its page 0.

An access completes in the first cycle in which the strobe is high and wait is low. Read data is valid in that same cycle, and a write takes effect at the clock edge that ends it.

Top module: `pkt_window`

## Requirements
- R1: After reset the page register reads 0, the length reads 0, every window byte reads 0, and wait and pop are low.
- R2: When no packet is loaded and the queue reports a head, the block latches that head's base and length, selects page 0 and fills the window without any bus action.
- R3: Window byte i (address 0x00 to 0x3F) shows packet byte page*64+i. It is taken from storage word base+page*16+i/4, at bits 8*(i%4)+7 down to 8*(i%4), so byte 0 of a word is its least significant byte.
- R4: Writing register 0x40 sets the page number and, while a packet is loaded, refills the window from storage word base+page*16. Reading 0x40 returns the page number.
- R5: Once a refill starts, every access to any address other than 0x43 sees wait high for exactly 17 cycles. A write held in wait changes nothing.
- R6: Register 0x41 returns bits 7:0 of the loaded packet's length, and 0x42 returns bits 15:8.
- R7: Register 0x43 never waits. Its bit 0 is 1 when the queue is empty, its bit 1 is 1 while a refill runs, and its other bits are 0.
- R8: A write to register 0x44 while a packet is loaded pulses pop for exactly one cycle, clears the length and page, and leads to page 0 of the next head being loaded. With no packet loaded, the write produces no pop.
- R9: A window byte whose packet offset page*64+i is not below the packet length reads 0, and so does every window byte while no packet is loaded.
- R10: Writes to the window and to addresses 0x45 to 0xFF are ignored, and those addresses read 0.
- R11: A refill reads 16 consecutive storage words, one per cycle, starting at base+page*16. Each word reaches the window one cycle after its read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe, held until wait is low |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid when wait is low |
| bus_wait | output | 1 | Stall for the current access |
| q_valid | input | 1 | Queue has a head packet |
| q_base | input | MEM_AW | Head packet word base address |
| q_len | input | LEN_W | Head packet length in bytes |
| q_pop | output | 1 | Remove the head packet |
| mem_rd_en | output | 1 | Storage word read request |
| mem_addr | output | MEM_AW | Storage word address |
| mem_rdata | input | WORD_W | Storage data, one cycle after the request |

## Verification
On every cycle, the assertions check the following:
- Storage addresses in a burst step by one, and a window write follows each read.
- A refill never starts while one is running, and no refill lasts longer than 17 cycles.
- A page write held in wait leaves the page unchanged.
- Pop never lasts two cycles and never fires on a release with an empty queue.
- The window reads zero while nothing is loaded.

Only the bench scenarios can show the following:
- The byte order within a word and the page-to-word mapping.
- The zeroing at a packet tail that ends mid-word.
- The exact 17-cycle stall seen by a waiting access.
- The handover to the next queued packet after release.

// File: rtl/pwin_pkg.sv
package pwin_pkg;
    // Control register offsets; the window occupies the addresses below REG_PAGE.
    localparam logic [7:0] REG_PAGE    = 8'h40;
    localparam logic [7:0] REG_LEN_LO  = 8'h41;
    localparam logic [7:0] REG_LEN_HI  = 8'h42;
    localparam logic [7:0] REG_STATUS  = 8'h43;
    localparam logic [7:0] REG_RELEASE = 8'h44;
    // Status bit positions
    localparam int ST_EMPTY = 0;
    localparam int ST_BUSY  = 1;
endpackage

// File: rtl/pwin_refill.sv
module pwin_refill #(
    parameter int WORDS  = 16,
    parameter int WORD_W = 32,
    parameter int MEM_AW = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [MEM_AW-1:0]        start_addr,
    output logic                     mem_rd_en,
    output logic [MEM_AW-1:0]        mem_addr,
    input  logic [WORD_W-1:0]        mem_rdata,
    output logic                     wr_en,
    output logic [$clog2(WORDS)-1:0] wr_idx,
    output logic [WORD_W-1:0]        wr_data,
    output logic                     busy
);
    localparam int IDX_W = $clog2(WORDS);

    typedef struct packed {
        logic              issuing;
        logic [IDX_W-1:0]  cnt;
        logic [MEM_AW-1:0] base;
        logic              pend;
        logic [IDX_W-1:0]  pend_idx;
    } fill_t;

    fill_t fill_d, fill_q;

    always_comb begin
        fill_d      = fill_q;
        fill_d.pend = 1'b0;
        if (fill_q.issuing) begin
            fill_d.pend     = 1'b1;
            fill_d.pend_idx = fill_q.cnt;
            fill_d.cnt      = fill_q.cnt + 1'b1;
            if (fill_q.cnt == IDX_W'(WORDS - 1)) begin
                fill_d.issuing = 1'b0;
            end
        end
        if (start) begin
            fill_d.issuing = 1'b1;
            fill_d.cnt     = '0;
            fill_d.base    = start_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else begin
            fill_q <= fill_d;
        end
    end

    assign mem_rd_en = fill_q.issuing;
    assign mem_addr  = fill_q.base + MEM_AW'(fill_q.cnt);
    assign wr_en     = fill_q.pend;
    assign wr_idx    = fill_q.pend_idx;
    assign wr_data   = mem_rdata;
    assign busy      = fill_q.issuing | fill_q.pend;

    // R11: burst addresses are consecutive
    p_addr_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + 1'b1));

    // R11: each storage read is written into the window on the next cycle
    p_write_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> wr_en);

    // R5: the controller never restarts a refill in progress
    p_start_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/pwin_window.sv
module pwin_window #(
    parameter int WORDS  = 16,
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      wr_en,
    input  logic [$clog2(WORDS)-1:0]                  wr_idx,
    input  logic [WORD_W-1:0]                         wr_data,
    input  logic [$clog2(WORDS*WORD_W/BYTE_W)-1:0]    rd_byte,
    output logic [BYTE_W-1:0]                         rd_data
);
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int LANE_W = $clog2(LANES);
    localparam int BA_W   = $clog2(WORDS * LANES);

    logic [WORD_W-1:0] words_d [WORDS];
    logic [WORD_W-1:0] words_q [WORDS];
    logic [WORD_W-1:0] sel_word;
    logic [BYTE_W-1:0] lane_byte [LANES];

    always_comb begin
        words_d = words_q;
        if (wr_en) begin
            words_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                words_q[w] <= '0;
            end
        end else begin
            words_q <= words_d;
        end
    end

    assign sel_word = words_q[rd_byte[BA_W-1:LANE_W]];

    // Lane 0 is the least significant byte of a word.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_byte[l] = sel_word[l*BYTE_W +: BYTE_W];
    end

    assign rd_data = lane_byte[rd_byte[LANE_W-1:0]];
endmodule

// File: rtl/pkt_window.sv
module pkt_window
    import pwin_pkg::*;
#(
    parameter int MEM_AW    = 10,
    parameter int LEN_W     = 16,
    parameter int WORD_W    = 32,
    parameter int WIN_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_wait,
    input  logic              q_valid,
    input  logic [MEM_AW-1:0] q_base,
    input  logic [LEN_W-1:0]  q_len,
    output logic              q_pop,
    output logic              mem_rd_en,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int BYTE_W     = 8;
    localparam int WORDS      = WIN_BYTES * BYTE_W / WORD_W;
    localparam int WIN_AW     = $clog2(WIN_BYTES);
    localparam int WORD_AW    = $clog2(WORDS);
    localparam int REFILL_CYC = WORDS + 1;
    localparam int RUN_W      = $clog2(REFILL_CYC + 2) + 1;

    typedef struct packed {
        logic [7:0]        page;
        logic              loaded;
        logic [MEM_AW-1:0] base;
        logic [LEN_W-1:0]  len;
    } regs_t;

    regs_t regs_d, regs_q;

    logic               busy;
    logic               start;
    logic [MEM_AW-1:0]  start_addr;
    logic               acc_ok;
    logic               wr_ok;
    logic               fill_we;
    logic [WORD_AW-1:0] fill_idx;
    logic [WORD_W-1:0]  fill_data;
    logic [7:0]         win_byte;
    logic [31:0]        pkt_off;
    logic               in_pkt;

    assign bus_wait = bus_sel && busy && (bus_addr != REG_STATUS);
    assign acc_ok   = bus_sel && !bus_wait;
    assign wr_ok    = acc_ok && bus_we;

    always_comb begin
        regs_d = regs_q;
        start  = 1'b0;
        q_pop  = 1'b0;
        if (wr_ok && bus_addr == REG_PAGE) begin
            regs_d.page = bus_wdata;
            start       = regs_q.loaded;
        end
        if (wr_ok && bus_addr == REG_RELEASE && regs_q.loaded) begin
            q_pop         = 1'b1;
            regs_d.loaded = 1'b0;
            regs_d.page   = '0;
            regs_d.len    = '0;
        end
        if (!regs_q.loaded && q_valid && !busy) begin
            regs_d.loaded = 1'b1;
            regs_d.base   = q_base;
            regs_d.len    = q_len;
            regs_d.page   = '0;
            start         = 1'b1;
        end
        start_addr = regs_d.base + MEM_AW'({regs_d.page, {WORD_AW{1'b0}}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    pwin_refill #(
        .WORDS (WORDS),
        .WORD_W(WORD_W),
        .MEM_AW(MEM_AW)
    ) u_refill (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_addr(start_addr),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .wr_en     (fill_we),
        .wr_idx    (fill_idx),
        .wr_data   (fill_data),
        .busy      (busy)
    );

    pwin_window #(
        .WORDS (WORDS),
        .WORD_W(WORD_W),
        .BYTE_W(BYTE_W)
    ) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (fill_we),
        .wr_idx (fill_idx),
        .wr_data(fill_data),
        .rd_byte(bus_addr[WIN_AW-1:0]),
        .rd_data(win_byte)
    );

    assign pkt_off = 32'({regs_q.page, bus_addr[WIN_AW-1:0]});
    assign in_pkt  = regs_q.loaded && (pkt_off < 32'(regs_q.len));

    always_comb begin
        bus_rdata = '0;
        if (bus_addr < 8'(WIN_BYTES)) begin
            bus_rdata = in_pkt ? win_byte : '0;
        end else begin
            case (bus_addr)
                REG_PAGE:   bus_rdata = regs_q.page;
                REG_LEN_LO: bus_rdata = regs_q.len[7:0];
                REG_LEN_HI: bus_rdata = 8'(regs_q.len >> 8);
                REG_STATUS: begin
                    bus_rdata[ST_EMPTY] = !q_valid;
                    bus_rdata[ST_BUSY]  = busy;
                end
                default:    bus_rdata = '0;
            endcase
        end
    end

    // Checker state: length of the current run of refill cycles.
    logic [RUN_W-1:0] busy_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run_q <= '0;
        end else if (busy) begin
            busy_run_q <= busy_run_q + 1'b1;
        end else begin
            busy_run_q <= '0;
        end
    end

    // R5: a refill ends within its fixed budget
    p_busy_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run_q <= RUN_W'(REFILL_CYC));

    // R5: a page write held in wait leaves the page untouched
    p_hold_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_wait && bus_addr == REG_PAGE) |=> (regs_q.page == $past(regs_q.page)));

    // R8: pop is a single-cycle pulse
    p_pop_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |=> !q_pop);

    // R8: release with an empty queue pops nothing
    p_release_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && bus_we && bus_addr == REG_RELEASE && !q_valid) |-> !q_pop);

    // R9: window reads zero while no packet is loaded
    p_unloaded_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && bus_addr < 8'(WIN_BYTES) && !regs_q.loaded) |-> (bus_rdata == 8'h00));
endmodule

// File: tb/test_pkt_window.sv
module test_pkt_window;
    localparam int MEM_AW = 10;
    localparam int NPKT   = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic              bus_wait;
    logic              q_valid;
    logic [MEM_AW-1:0] q_base;
    logic [15:0]       q_len;
    logic              q_pop;
    logic              mem_rd_en;
    logic [MEM_AW-1:0] mem_addr;
    logic [31:0]       mem_rdata = '0;

    logic [31:0] mem [1 << MEM_AW];
    int pbase [NPKT] = '{0, 300, 500};
    int plen  [NPKT] = '{200, 64, 5};
    int hd = 0;
    int avail = 0;
    int pops = 0;
    int total = 0;
    int fails = 0;
    int cyc = 0;
    logic prev_rd = 1'b0;
    int first_addr = -1;
    int burst_len = 0;

    always #4 clk = ~clk;

    pkt_window #(.MEM_AW(MEM_AW)) i_pkt_window (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_wait(bus_wait), .q_valid(q_valid), .q_base(q_base), .q_len(q_len),
        .q_pop(q_pop), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    assign q_valid = (hd < avail);
    assign q_base  = (hd < NPKT) ? MEM_AW'(pbase[hd]) : '0;
    assign q_len   = (hd < NPKT) ? 16'(plen[hd]) : '0;

    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
        if (q_pop) begin
            hd   <= hd + 1;
            pops <= pops + 1;
        end
        if (mem_rd_en && !prev_rd) begin
            first_addr <= int'(mem_addr);
            burst_len  <= 1;
        end else if (mem_rd_en) begin
            burst_len <= burst_len + 1;
        end
        prev_rd <= mem_rd_en;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_win(int p, int page, int i);
        int off;
        logic [31:0] w;
        off = page * 64 + i;
        if (off >= plen[p]) return 8'h00;
        w = mem[(pbase[p] + page * 16 + i / 4) % (1 << MEM_AW)];
        return w[8*(i%4) +: 8];
    endfunction

    // Called just after a rising edge; returns after the accepting edge plus 1.
    task automatic bus_acc(input logic we, input logic [7:0] a, input logic [7:0] wd,
                           output logic [7:0] rd, output int nw);
        bit done;
        bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
        nw = 0; done = 0; rd = '0;
        while (!done) begin
            @(negedge clk);
            if (!bus_wait) begin
                rd = bus_rdata;
                done = 1;
            end else begin
                nw++;
            end
            @(posedge clk); #1;
        end
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] rd;
        int nw;
        repeat (2) begin @(posedge clk); #1; end
        rd = 8'h02;
        while (rd[1]) bus_acc(1'b0, 8'h43, 8'h00, rd, nw);
    endtask

    task automatic check_page(string req, int p, int page);
        logic [7:0] rd;
        int nw;
        for (int i = 0; i < 64; i++) begin
            bus_acc(1'b0, 8'(i), 8'h00, rd, nw);
            chk(req, {24'h0, rd}, {24'h0, exp_win(p, page, i)});
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int nw;
        int pg;
        void'($urandom(32'h5eed));
        for (int m = 0; m < (1 << MEM_AW); m++) mem[m] = $urandom();

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 / R7 reset state
        chk("R1 wait", {31'h0, bus_wait}, 0);
        chk("R1 pop", {31'h0, q_pop}, 0);
        bus_acc(1'b0, 8'h43, 8'h00, rd, nw); chk("R7 status empty", {24'h0, rd}, 32'h01);
        bus_acc(1'b0, 8'h40, 8'h00, rd, nw); chk("R1 page", {24'h0, rd}, 0);
        bus_acc(1'b0, 8'h41, 8'h00, rd, nw); chk("R1 len", {24'h0, rd}, 0);
        bus_acc(1'b0, 8'h05, 8'h00, rd, nw); chk("R1 window", {24'h0, rd}, 0);

        // R2 autoload of the first head
        avail = NPKT;
        wait_idle();
        chk("R11 first addr", first_addr, pbase[0]);
        chk("R11 burst", burst_len, 16);
        bus_acc(1'b0, 8'h41, 8'h00, rd, nw); chk("R6 len lo", {24'h0, rd}, 32'hC8);
        bus_acc(1'b0, 8'h42, 8'h00, rd, nw); chk("R6 len hi", {24'h0, rd}, 0);
        check_page("R2 R3 page0", 0, 0);

        // R4 / R5 page 3: tail at 200 bytes
        bus_acc(1'b1, 8'h40, 8'd3, rd, nw);
        bus_acc(1'b0, 8'h10, 8'h00, rd, nw);
        chk("R5 wait cycles", nw, 17);
        chk("R5 read after wait", {24'h0, rd}, {24'h0, exp_win(0, 3, 16)});
        chk("R11 page3 addr", first_addr, pbase[0] + 48);
        chk("R11 page3 burst", burst_len, 16);
        bus_acc(1'b0, 8'h40, 8'h00, rd, nw); chk("R4 page readback", {24'h0, rd}, 3);
        check_page("R4 R9 page3", 0, 3);

        // R7 status during refill, R5 blocked page write
        bus_acc(1'b1, 8'h40, 8'd1, rd, nw);
        bus_acc(1'b0, 8'h43, 8'h00, rd, nw);
        chk("R7 status no wait", nw, 0);
        chk("R7 status busy", {24'h0, rd}, 32'h02);
        bus_acc(1'b1, 8'h40, 8'd2, rd, nw);
        chk("R5 write waited", {31'h0, nw > 0}, 1);
        wait_idle();
        bus_acc(1'b0, 8'h40, 8'h00, rd, nw); chk("R4 page after wait", {24'h0, rd}, 2);

        // R4 random pages and bytes
        for (int k = 0; k < 24; k++) begin
            pg = $urandom_range(0, 4);
            bus_acc(1'b1, 8'h40, 8'(pg), rd, nw);
            wait_idle();
            for (int j = 0; j < 6; j++) begin
                int a;
                a = $urandom_range(0, 63);
                bus_acc(1'b0, 8'(a), 8'h00, rd, nw);
                chk("R4 R3 random", {24'h0, rd}, {24'h0, exp_win(0, pg, a)});
            end
        end

        // R10 ignored writes
        bus_acc(1'b1, 8'h40, 8'd0, rd, nw);
        wait_idle();
        bus_acc(1'b1, 8'h80, 8'h5A, rd, nw);
        bus_acc(1'b0, 8'h80, 8'h00, rd, nw); chk("R10 high addr", {24'h0, rd}, 0);
        bus_acc(1'b1, 8'h03, ~exp_win(0, 0, 3), rd, nw);
        bus_acc(1'b0, 8'h03, 8'h00, rd, nw); chk("R10 window ro", {24'h0, rd}, {24'h0, exp_win(0, 0, 3)});

        // R8 release to packet 1 (exactly 64 bytes)
        bus_acc(1'b1, 8'h44, 8'h00, rd, nw);
        chk("R8 pop count", pops, 1);
        wait_idle();
        bus_acc(1'b0, 8'h41, 8'h00, rd, nw); chk("R8 R6 next len", {24'h0, rd}, 64);
        bus_acc(1'b0, 8'h40, 8'h00, rd, nw); chk("R8 page reset", {24'h0, rd}, 0);
        check_page("R8 R3 pkt1", 1, 0);
        bus_acc(1'b1, 8'h40, 8'd1, rd, nw);
        wait_idle();
        check_page("R9 beyond len", 1, 1);

        // Packet 2: 5 bytes, tail inside a word
        bus_acc(1'b1, 8'h44, 8'h00, rd, nw);
        wait_idle();
        chk("R8 pop count 2", pops, 2);
        check_page("R9 mid-word tail", 2, 0);

        // Queue drained, then release ignored
        bus_acc(1'b1, 8'h44, 8'h00, rd, nw);
        wait_idle();
        chk("R8 pop count 3", pops, 3);
        bus_acc(1'b0, 8'h43, 8'h00, rd, nw); chk("R7 empty again", {24'h0, rd}, 32'h01);
        bus_acc(1'b0, 8'h41, 8'h00, rd, nw); chk("R8 len cleared", {24'h0, rd}, 0);
        bus_acc(1'b1, 8'h44, 8'h00, rd, nw);
        repeat (2) begin @(posedge clk); #1; end
        chk("R8 empty release", pops, 3);
        bus_acc(1'b0, 8'h00, 8'h00, rd, nw); chk("R9 unloaded", {24'h0, rd}, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule